// File: doc/BRIEF.md
# Transmit Path Diagnostic Flag Unit

This block watches the digital side of a differential bus transmitter and produces its fault and protection flags. It compares transmitted and received edges to detect a broken loopback. It samples the digitised current comparators of the four driver halves once the transmitted level has been stable long enough, and derives open-line and short-circuit flags from those samples. It also times a stuck transmit enable and tracks over-temperature with hysteresis. Both of these last two conditions switch the driver off.

All inputs are already synchronised to the block clock. The mode controller supplies the operating mode (`2'b00` power off, `2'b01` standby, `2'b10` normal; `2'b11` is treated as a non-normal, powered mode). The block drives the driver-enable level, every individual flag, an OR of all flags, and an active-low error pin level.

Driver halves are indexed as follows: 0 = plus line high side, 1 = plus line low side, 2 = minus line high side, 3 = minus line low side. For line k, the high side is half 2k and the low side is half 2k+1 (k = 0 plus, k = 1 minus).

Top module: `txdiag_top`

## Requirements
- R1: With diagnostics active, a transmit-data rising edge that follows an earlier transmit-data rising edge with no received-data rising edge in between sets `bus_err_o` on the next clock.
- R2: With diagnostics active, two transmit-data falling edges with no received-data falling edge between them set `bus_err_o` in the same way.
- R3: A received-data edge that matches the polarity of a pending, unmatched transmit-data edge clears `bus_err_o`, unless a set condition occurs in the same cycle.
- R4: Diagnostics are active only while `drv_en_o` is high. Outside that, bus error, current and line-short flags hold and pending edges are dropped. In power off, every flag is cleared.
- R5: Once transmit data has been unchanged for `DLY_CYC` active cycles, the current flags are sampled once. At data1 (`txd_i`=1), halves 0 and 3 are sampled; at data0, halves 1 and 2 are sampled. `low_flg_o[i]` takes `cur_low_i[i]` and `high_flg_o[i]` takes `cur_high_i[i]`.
- R6: For each line k:
  - `open_o[k]` is the low flag of both of its halves.
  - `short_vcc_o[k]` is the low flag of its high side AND the high flag of its low side.
  - `short_gnd_o[k]` is the high flag of its high side AND the low flag of its low side.
- R7: At the same sampling point, `line_short_o` takes `diff_short_i`.
- R8: `tmo_o` sets after `TMO_CYC` cycles in normal mode with `bge_i`=1 and `txen_ni`=0 unchanged. It clears when either enable input changes or when the mode is not normal.
- R9: In normal mode, `ot_o` sets on `ot_hot_i` and clears on `ot_cool_i` (set wins). It holds in non-normal powered modes and clears in power off.
- R10: `err_sum_o` is the OR of all flags and `uv_io_i`. `err_no` is low only in normal mode with `err_sum_o` high.
- R11: `drv_en_o` is high only in normal mode with `bge_i`=1, `txen_ni`=0, and neither `ot_o` nor `tmo_o` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode from the mode controller |
| txd_i | input | 1 | Transmit data |
| txen_ni | input | 1 | Transmit enable, active low |
| bge_i | input | 1 | Guardian enable |
| rxd_i | input | 1 | Received data |
| uv_io_i | input | 1 | I/O supply undervoltage flag |
| cur_low_i | input | 4 | Per-half comparator: current below low threshold |
| cur_high_i | input | 4 | Per-half comparator: current above high threshold |
| diff_short_i | input | 1 | Differential voltage below short threshold |
| ot_hot_i | input | 1 | Temperature above set threshold |
| ot_cool_i | input | 1 | Temperature below clear threshold |
| drv_en_o | output | 1 | Driver enable |
| bus_err_o | output | 1 | Loopback edge mismatch flag |
| low_flg_o | output | 4 | Sampled low-current flags per half |
| high_flg_o | output | 4 | Sampled high-current flags per half |
| open_o | output | 2 | Open-line flag per line |
| short_vcc_o | output | 2 | Short-to-supply flag per line |
| short_gnd_o | output | 2 | Short-to-ground flag per line |
| line_short_o | output | 1 | Short between the lines |
| tmo_o | output | 1 | Transmit-enable timeout |
| ot_o | output | 1 | Over-temperature flag |
| err_sum_o | output | 1 | OR of all flags and undervoltage |
| err_no | output | 1 | Error pin level, active low |

## Verification
The assertions assume that every input changes only on clock boundaries and that `ot_hot_i` and `ot_cool_i` are never high together. The stimulus drives all inputs at the falling clock edge. It draws the two temperature comparators as exclusive events. Transmit data toggles often enough to make edge pairs, yet stays stable long enough to reach the sampling point. The enable inputs change rarely, so that the long timeout window can elapse inside the random phase as well as in the directed one.

// File: rtl/txdiag_pkg.sv
package txdiag_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_STBY = 2'b01,
    MODE_NORM = 2'b10
  } txdiag_mode_e;

  localparam int NUM_HALVES = 4;
  localparam int NUM_LINES  = NUM_HALVES / 2;
endpackage

// File: rtl/txdiag_edge_chk.sv
module txdiag_edge_chk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_off_i,
  input  logic active_i,
  input  logic txd_i,
  input  logic rxd_i,
  output logic bus_err_o
);
  logic txd_q, rxd_q, pr_q, pf_q, err_q;
  logic pr_d, pf_d, err_d;
  logic tx_rise, tx_fall, rx_rise, rx_fall, set_c, clr_c;

  assign tx_rise = txd_i & ~txd_q;
  assign tx_fall = ~txd_i & txd_q;
  assign rx_rise = rxd_i & ~rxd_q;
  assign rx_fall = ~rxd_i & rxd_q;
  assign set_c   = (tx_rise & pr_q & ~rx_rise) | (tx_fall & pf_q & ~rx_fall);
  assign clr_c   = (rx_rise & pr_q) | (rx_fall & pf_q);

  always_comb begin
    pr_d  = pr_q;
    pf_d  = pf_q;
    err_d = err_q;
    if (pwr_off_i) begin
      pr_d  = 1'b0;
      pf_d  = 1'b0;
      err_d = 1'b0;
    end else if (!active_i) begin
      pr_d = 1'b0;
      pf_d = 1'b0;
    end else begin
      if (tx_rise)      pr_d = 1'b1;
      else if (rx_rise) pr_d = 1'b0;
      if (tx_fall)      pf_d = 1'b1;
      else if (rx_fall) pf_d = 1'b0;
      if (set_c)        err_d = 1'b1;
      else if (clr_c)   err_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txd_q <= 1'b0;
      rxd_q <= 1'b0;
      pr_q  <= 1'b0;
      pf_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      txd_q <= txd_i;
      rxd_q <= rxd_i;
      pr_q  <= pr_d;
      pf_q  <= pf_d;
      err_q <= err_d;
    end
  end

  assign bus_err_o = err_q;

  AST_BERR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !pwr_off_i) |=> $stable(bus_err_o)); // R4
  AST_BERR_OFF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_off_i |=> !bus_err_o); // R4
  AST_BERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !pwr_off_i && tx_rise && pr_q && !rx_rise) |=> bus_err_o); // R1
endmodule

// File: rtl/txdiag_cur_sample.sv
module txdiag_cur_sample
  import txdiag_pkg::*;
#(
  parameter int DLY_CYC = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pwr_off_i,
  input  logic                  active_i,
  input  logic                  txd_i,
  input  logic [NUM_HALVES-1:0] cur_low_i,
  input  logic [NUM_HALVES-1:0] cur_high_i,
  input  logic                  diff_short_i,
  output logic [NUM_HALVES-1:0] low_flg_o,
  output logic [NUM_HALVES-1:0] high_flg_o,
  output logic                  line_short_o
);
  localparam int CW = $clog2(DLY_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DLY_CYC - 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(DLY_CYC);

  logic          txd_q, short_q, short_d, edge_c, strobe;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [NUM_HALVES-1:0] lo_q, lo_d, hi_q, hi_d;

  assign edge_c = txd_i ^ txd_q;
  assign strobe = active_i & ~edge_c & (cnt_q == CNT_LAST);

  always_comb begin
    if (!active_i || edge_c)  cnt_d = '0;
    else if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    else                       cnt_d = cnt_q;
  end

  for (genvar i = 0; i < NUM_HALVES; i++) begin : g_half
    localparam bit ON_DATA1 = (i == 0) || (i == NUM_HALVES - 1);
    logic pick;
    assign pick    = ON_DATA1 ? txd_i : ~txd_i;
    assign lo_d[i] = pwr_off_i ? 1'b0 : ((strobe & pick) ? cur_low_i[i]  : lo_q[i]);
    assign hi_d[i] = pwr_off_i ? 1'b0 : ((strobe & pick) ? cur_high_i[i] : hi_q[i]);
  end

  assign short_d = pwr_off_i ? 1'b0 : (strobe ? diff_short_i : short_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txd_q   <= 1'b0;
      cnt_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      short_q <= 1'b0;
    end else begin
      txd_q   <= txd_i;
      cnt_q   <= cnt_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      short_q <= short_d;
    end
  end

  assign low_flg_o    = lo_q;
  assign high_flg_o   = hi_q;
  assign line_short_o = short_q;

  AST_CUR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !pwr_off_i) |=> $stable({low_flg_o, high_flg_o, line_short_o})); // R4
  AST_CUR_OFF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_off_i |=> (low_flg_o == '0 && high_flg_o == '0 && !line_short_o)); // R4
  AST_CUR_HOLD_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_c && !pwr_off_i) |=> $stable({low_flg_o, high_flg_o})); // R5
endmodule

// File: rtl/txdiag_en_wdog.sv
module txdiag_en_wdog #(
  parameter int TMO_CYC = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic is_norm_i,
  input  logic txen_ni,
  input  logic bge_i,
  output logic tmo_o
);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [TW-1:0] CNT_LAST = TW'(TMO_CYC - 1);

  logic          txen_q, bge_q, tmo_q, tmo_d, chg, armed;
  logic [TW-1:0] cnt_q, cnt_d;

  assign chg   = (txen_ni ^ txen_q) | (bge_i ^ bge_q);
  assign armed = is_norm_i & bge_i & ~txen_ni;

  always_comb begin
    cnt_d = cnt_q;
    tmo_d = tmo_q;
    if (!is_norm_i || chg) begin
      cnt_d = '0;
      tmo_d = 1'b0;
    end else if (armed) begin
      if (cnt_q == CNT_LAST) tmo_d = 1'b1;
      else                   cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txen_q <= 1'b0;
      bge_q  <= 1'b0;
      cnt_q  <= '0;
      tmo_q  <= 1'b0;
    end else begin
      txen_q <= txen_ni;
      bge_q  <= bge_i;
      cnt_q  <= cnt_d;
      tmo_q  <= tmo_d;
    end
  end

  assign tmo_o = tmo_q;

  AST_TMO_LEAVE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_norm_i |=> !tmo_o); // R8
  AST_TMO_CHG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> !tmo_o); // R8
endmodule

// File: rtl/txdiag_top.sv
module txdiag_top
  import txdiag_pkg::*;
#(
  parameter int DLY_CYC = 8,
  parameter int TMO_CYC = 400
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       txd_i,
  input  logic       txen_ni,
  input  logic       bge_i,
  input  logic       rxd_i,
  input  logic       uv_io_i,
  input  logic [3:0] cur_low_i,
  input  logic [3:0] cur_high_i,
  input  logic       diff_short_i,
  input  logic       ot_hot_i,
  input  logic       ot_cool_i,
  output logic       drv_en_o,
  output logic       bus_err_o,
  output logic [3:0] low_flg_o,
  output logic [3:0] high_flg_o,
  output logic [1:0] open_o,
  output logic [1:0] short_vcc_o,
  output logic [1:0] short_gnd_o,
  output logic       line_short_o,
  output logic       tmo_o,
  output logic       ot_o,
  output logic       err_sum_o,
  output logic       err_no
);
  logic is_norm, pwr_off, drv_en, ot_q, ot_d, tmo;
  logic [NUM_HALVES-1:0] lo_flg, hi_flg;

  assign is_norm = (mode_i == MODE_NORM);
  assign pwr_off = (mode_i == MODE_OFF);
  assign drv_en  = is_norm & bge_i & ~txen_ni & ~ot_q & ~tmo;

  always_comb begin
    ot_d = ot_q;
    if (pwr_off)       ot_d = 1'b0;
    else if (is_norm) begin
      if (ot_hot_i)       ot_d = 1'b1;
      else if (ot_cool_i) ot_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ot_q <= 1'b0;
    else         ot_q <= ot_d;
  end

  txdiag_edge_chk u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_off_i(pwr_off), .active_i(drv_en),
    .txd_i(txd_i), .rxd_i(rxd_i), .bus_err_o(bus_err_o)
  );

  txdiag_cur_sample #(.DLY_CYC(DLY_CYC)) u_cur (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_off_i(pwr_off), .active_i(drv_en),
    .txd_i(txd_i), .cur_low_i(cur_low_i), .cur_high_i(cur_high_i),
    .diff_short_i(diff_short_i), .low_flg_o(lo_flg), .high_flg_o(hi_flg),
    .line_short_o(line_short_o)
  );

  txdiag_en_wdog #(.TMO_CYC(TMO_CYC)) u_wdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .is_norm_i(is_norm), .txen_ni(txen_ni),
    .bge_i(bge_i), .tmo_o(tmo)
  );

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    localparam int HS = 2 * k;
    localparam int LS = 2 * k + 1;
    assign open_o[k]      = lo_flg[HS] & lo_flg[LS];
    assign short_vcc_o[k] = lo_flg[HS] & hi_flg[LS];
    assign short_gnd_o[k] = hi_flg[HS] & lo_flg[LS];
  end

  assign low_flg_o  = lo_flg;
  assign high_flg_o = hi_flg;
  assign tmo_o      = tmo;
  assign ot_o       = ot_q;
  assign drv_en_o   = drv_en;
  assign err_sum_o  = bus_err_o | (|lo_flg) | (|hi_flg) | (|open_o) | (|short_vcc_o)
                    | (|short_gnd_o) | line_short_o | tmo | ot_q | uv_io_i;
  assign err_no     = ~(is_norm & err_sum_o);

  AST_DRV_OFF_TMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> !drv_en_o); // R11
  AST_DRV_OFF_OT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_o |-> !drv_en_o); // R11
  AST_OT_STBY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STBY) |=> $stable(ot_o)); // R9
  AST_ERRPIN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_norm |-> err_no); // R10
endmodule

// File: tb/txdiag_top_tb_top.sv
module txdiag_top_tb_top;
  localparam int DLY = 8;
  localparam int TMO = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic txd = 0, txen_n = 1, bge = 0, rxd = 0, uv = 0;
  logic [3:0] clo = '0, chi = '0;
  logic dshort = 0, hot = 0, cool = 0;

  logic drv_en, bus_err, line_short, tmo, ot, err_sum, err_n;
  logic [3:0] lo_f, hi_f;
  logic [1:0] open_f, svcc_f, sgnd_f;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  txdiag_top #(.DLY_CYC(DLY), .TMO_CYC(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .txd_i(txd), .txen_ni(txen_n),
    .bge_i(bge), .rxd_i(rxd), .uv_io_i(uv), .cur_low_i(clo), .cur_high_i(chi),
    .diff_short_i(dshort), .ot_hot_i(hot), .ot_cool_i(cool), .drv_en_o(drv_en),
    .bus_err_o(bus_err), .low_flg_o(lo_f), .high_flg_o(hi_f), .open_o(open_f),
    .short_vcc_o(svcc_f), .short_gnd_o(sgnd_f), .line_short_o(line_short),
    .tmo_o(tmo), .ot_o(ot), .err_sum_o(err_sum), .err_no(err_n)
  );

  // reference state, derived from the requirements
  bit m_txq, m_rxq, m_pr, m_pf, m_berr, m_sll, m_tmo, m_ot, m_txenq, m_bgeq;
  bit [3:0] m_lo, m_hi;
  int m_cnt, m_tcnt;

  function automatic bit exp_drv();
    return (mode == 2'b10) && bge && !txen_n && !m_ot && !m_tmo;
  endfunction

  function automatic bit [1:0] exp_open();
    return {m_lo[2] & m_lo[3], m_lo[0] & m_lo[1]};
  endfunction
  function automatic bit [1:0] exp_svcc();
    return {m_lo[2] & m_hi[3], m_lo[0] & m_hi[1]};
  endfunction
  function automatic bit [1:0] exp_sgnd();
    return {m_hi[2] & m_lo[3], m_hi[0] & m_lo[1]};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit pwr, nrm, drv, tr, tf, rr, rf, st, cl, ed, strobe, chg, armed, upd;
    pwr = (mode == 2'b00);
    nrm = (mode == 2'b10);
    drv = exp_drv();
    tr = txd & !m_txq;  tf = !txd & m_txq;
    rr = rxd & !m_rxq;  rf = !rxd & m_rxq;
    if (pwr) begin
      m_pr = 0; m_pf = 0; m_berr = 0;
    end else if (!drv) begin
      m_pr = 0; m_pf = 0;
    end else begin
      st = (tr && m_pr && !rr) || (tf && m_pf && !rf);
      cl = (rr && m_pr) || (rf && m_pf);
      if (tr) m_pr = 1; else if (rr) m_pr = 0;
      if (tf) m_pf = 1; else if (rf) m_pf = 0;
      if (st) m_berr = 1; else if (cl) m_berr = 0;
    end
    ed = tr | tf;
    strobe = drv && !ed && (m_cnt == DLY - 1);
    if (pwr) begin
      m_lo = '0; m_hi = '0; m_sll = 0;
    end else if (strobe) begin
      for (int i = 0; i < 4; i++) begin
        upd = (i == 0 || i == 3) ? txd : !txd;
        if (upd) begin m_lo[i] = clo[i]; m_hi[i] = chi[i]; end
      end
      m_sll = dshort;
    end
    if (!drv || ed) m_cnt = 0; else if (m_cnt != DLY) m_cnt++;
    chg = (txen_n != m_txenq) || (bge != m_bgeq);
    armed = nrm && bge && !txen_n;
    if (!nrm || chg) begin m_tcnt = 0; m_tmo = 0; end
    else if (armed) begin
      if (m_tcnt == TMO - 1) m_tmo = 1; else m_tcnt++;
    end else m_tcnt = 0;
    if (pwr) m_ot = 0;
    else if (nrm) begin
      if (hot) m_ot = 1; else if (cool) m_ot = 0;
    end
    m_txq = txd; m_rxq = rxd; m_txenq = txen_n; m_bgeq = bge;
  endtask

  task automatic check_all();
    bit es;
    chk("R1 R2 R3 bus error", 16'(bus_err), 16'(m_berr));
    chk("R4 R5 current flags", {8'h0, lo_f, hi_f}, {8'h0, m_lo, m_hi});
    chk("R6 compound flags", {10'h0, open_f, svcc_f, sgnd_f},
        {10'h0, exp_open(), exp_svcc(), exp_sgnd()});
    chk("R7 line short", 16'(line_short), 16'(m_sll));
    chk("R8 enable timeout", 16'(tmo), 16'(m_tmo));
    chk("R9 over-temperature", 16'(ot), 16'(m_ot));
    es = m_berr || (|m_lo) || (|m_hi) || m_sll || m_tmo || m_ot || uv;
    chk("R10 error summary and pin", {14'h0, err_sum, err_n},
        {14'h0, es, !((mode == 2'b10) && es)});
    chk("R11 driver enable", 16'(drv_en), 16'(exp_drv()));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  function automatic bit chance(int n);
    return ($urandom % n) == 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit follow;
    bit txd_prev;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R4 reset flags", {lo_f, hi_f, 2'b0, bus_err, line_short, tmo, ot, drv_en, err_sum},
        16'h0);
    chk("R10 reset error pin", 16'(err_n), 16'h1);
    rst_n = 1'b1;
    // enter normal mode with driver enabled
    mode = 2'b10; bge = 1; txen_n = 0; run(3);
    // R1: two rises without a received rise
    txd = 1; run(2); txd = 0; run(2); txd = 1; run(2);
    chk("R1 directed set", 16'(bus_err), 16'h1);
    // R3: matching received rise clears
    rxd = 1; run(2);
    chk("R3 directed clear", 16'(bus_err), 16'h0);
    // R2: two falls without a received fall
    txd = 0; run(2); txd = 1; run(2); txd = 0; run(2);
    chk("R2 directed set", 16'(bus_err), 16'h1);
    rxd = 0; run(2);
    // R5 R6: open both lines
    clo = 4'hF; chi = 4'h0; txd = 1; run(DLY + 3); txd = 0; run(DLY + 3);
    chk("R6 open lines", {14'h0, open_f}, 16'h3);
    // short to supply on plus, short to ground on minus, line short
    clo = 4'b1001; chi = 4'b0110; dshort = 1; txd = 1; run(DLY + 3);
    txd = 0; run(DLY + 3);
    chk("R6 plus short supply", 16'(svcc_f[0]), 16'h1);
    chk("R7 line short set", 16'(line_short), 16'h1);
    // R4: flags frozen while driver disabled
    bge = 0; clo = 0; chi = 0; dshort = 0; txd = 1; run(DLY + 3);
    chk("R4 frozen when disabled", {lo_f, hi_f}, {8'h0, 4'b1001, 4'b0110} >> 0 & 16'hFF);
    bge = 1; run(DLY + 3); txd = 0; run(DLY + 3);
    // R9 over-temperature
    hot = 1; run(2); hot = 0; run(3);
    chk("R9 set holds", 16'(ot), 16'h1);
    mode = 2'b01; cool = 1; run(3);
    chk("R9 standby hold", 16'(ot), 16'h1);
    mode = 2'b10; run(3); cool = 0;
    chk("R9 cleared in normal", 16'(ot), 16'h0);
    // R8 timeout
    run(TMO + 10);
    chk("R8 timeout set", 16'(tmo), 16'h1);
    txen_n = 1; run(2); txen_n = 0; run(2);
    chk("R8 cleared on change", 16'(tmo), 16'h0);
    // R10 undervoltage pulls error pin
    uv = 1; run(2);
    chk("R10 undervoltage pin", 16'(err_n), 16'h0);
    uv = 0;
    // R4 power off clears everything
    mode = 2'b00; run(3);
    chk("R4 power off clear", {lo_f, hi_f, 3'b0, bus_err, line_short, tmo, ot, 1'b0},
        16'h0);
    mode = 2'b10; run(2);
    // random phase
    follow = 1; txd_prev = txd;
    for (int c = 0; c < 30000; c++) begin
      if (chance(500)) mode = (chance(4)) ? 2'b00 : (chance(3) ? 2'b01 : 2'b10);
      if (chance(900)) txen_n = !txen_n;
      if (chance(900)) bge = !bge;
      if (chance(200)) follow = !follow;
      if (follow) rxd = txd_prev;
      txd_prev = txd;
      if (chance(12)) txd = !txd;
      clo = 4'($urandom); chi = 4'($urandom); dshort = chance(3);
      uv = chance(300);
      hot = chance(3000);
      cool = !hot && chance(400);
      tick();
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule